// File: doc/BRIEF.md
# Watchdog Reset Controller with Reset-Pin Stretcher

This block produces the internal reset of a small controller from two sources: the bidirectional reset pad and a watchdog timer. The pad is sampled once per machine cycle, on a strobe supplied by the clock generator (one strobe every 12 oscillator periods). Internal reset is raised only after two consecutive machine-cycle samples have seen the pad high. It is released at the first later sample that sees the pad low.

The watchdog is a free-running oscillator-period counter. It stays idle after reset. Software starts it, and keeps restarting it, by writing a two-byte key to its restart register. If the counter wraps, the block issues a one-cycle internal reset pulse and stops the watchdog. It also drives the reset pad high for a fixed number of oscillator periods, so that the rest of the board sees the reset. A control bit in an auxiliary register suppresses this pad drive. Any internal reset clears that bit and the watchdog.

The register port is write-only. No register value can be read back.

Top module: `wdt_reset_ctrl`

## Requirements
- R1: After `rst`, both `sys_rst` and `pad_oe` are low, and the watchdog is idle: no timeout happens, however long the block runs without a key write.
- R2: `sys_rst` rises on the strobe edge that takes the second consecutive high sample of `pad_in`. A single high sample followed by a low one leaves `sys_rst` low.
- R3: While the pad holds it, `sys_rst` stays high until the first strobe edge that samples `pad_in` low, and falls on that edge.
- R4: A write of 0x1E and then a write of 0xE1 to the restart address (0xA6) enables the watchdog with a count of zero. The timeout then occurs on the 16384th clock edge after the edge that took the 0xE1 write.
- R5: A key write that does not complete the sequence has no effect on the watchdog. This covers 0xE1 without a preceding 0x1E, any other value written to the restart address between the two key bytes, and 0xE1 written to a different address.
- R6: Completing the key sequence while the watchdog runs resets its count to zero, which moves the timeout to 16384 edges after the new 0xE1 write.
- R7: On a timeout with the suppress bit clear, `pad_oe` goes high on the timeout edge and stays high for exactly 98 clock cycles.
- R8: Bit 3 of the auxiliary register (address 0x8E) suppresses the pad drive. With the bit set, a timeout gives the internal reset pulse but `pad_oe` stays low.
- R9: A timeout raises `sys_rst` for exactly one cycle and returns the watchdog to idle, so no second timeout follows without a new key sequence.
- R10: Any internal reset, whether from the pad or from a timeout, clears the suppress bit and returns the watchdog to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mc_stb | input | 1 | One-cycle strobe marking each machine-cycle boundary |
| pad_in | input | 1 | Level sensed on the reset pad |
| pad_oe | output | 1 | Drives the reset pad high while set |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| sys_rst | output | 1 | Internal reset to the rest of the controller |

## Verification
Every output comes straight from a register, so each result is due at a known clock edge. A pad change first shows on `sys_rst` at the strobe edge that samples it, which is a multiple of 12 cycles here. A timeout shows 16384 edges after the edge that took the 0xE1 write. `pad_oe` then holds for 98 edges, and `sys_rst` holds for one. The driver computes each expected output and the edge count at which it is due, queues it, and applies the stimulus. The monitor compares at the falling clock edge once that edge count is reached, and it checks one cycle on each side of every transition.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 8;

    localparam int unsigned DEF_WDT_W       = 14;
    localparam int unsigned DEF_STRETCH_LEN = 98;
    localparam int unsigned DEF_PAD_SAMPLES = 2;

    localparam logic [ADDR_W-1:0] DEF_KEY_ADDR = 8'hA6;
    localparam logic [ADDR_W-1:0] DEF_AUX_ADDR = 8'h8E;
    localparam int unsigned       DEF_DIS_BIT  = 3;
    localparam logic [DATA_W-1:0] DEF_KEY_A    = 8'h1E;
    localparam logic [DATA_W-1:0] DEF_KEY_B    = 8'hE1;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } key_seq_e;

    function automatic logic wr_hits(input reg_wr_t w, input logic [ADDR_W-1:0] a);
        return w.en && (w.addr == a);
    endfunction

endpackage

// File: rtl/rstctl_pad_filter.sv
module rstctl_pad_filter
    import rstctl_pkg::*;
#(
    parameter int unsigned SAMPLES = DEF_PAD_SAMPLES
) (
    input  logic clk,
    input  logic rst,
    input  logic mc_stb,
    input  logic pad_in,
    output logic ext_rst
);
    localparam int unsigned    CW   = $clog2(SAMPLES + 1);
    localparam logic [CW-1:0]  FULL = CW'(SAMPLES);

    logic [CW-1:0] run_q;

    // Count consecutive high samples, one per machine cycle, saturating.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (mc_stb) begin
            if (!pad_in)
                run_q <= '0;
            else if (run_q != FULL)
                run_q <= run_q + 1'b1;
        end
    end

    assign ext_rst = (run_q == FULL);

endmodule

// File: rtl/rstctl_wdt.sv
module rstctl_wdt
    import rstctl_pkg::*;
#(
    parameter int unsigned       CNT_W    = DEF_WDT_W,
    parameter logic [ADDR_W-1:0] KEY_ADDR = DEF_KEY_ADDR,
    parameter logic [DATA_W-1:0] KEY_A    = DEF_KEY_A,
    parameter logic [DATA_W-1:0] KEY_B    = DEF_KEY_B
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  reg_wr_t wr,
    output logic    timeout,
    output logic    fire_q,
    output logic    en_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    key_seq_e         seq_q, seq_d;
    logic             key_hit, restart;

    assign key_hit = wr_hits(wr, KEY_ADDR);
    assign restart = key_hit && (seq_q == SEQ_ARMED) && (wr.data == KEY_B);
    assign timeout = en_q && (cnt_q == CNT_MAX) && !restart && !clr;

    always_comb begin
        seq_d = seq_q;
        if (key_hit)
            seq_d = (!restart && wr.data == KEY_A) ? SEQ_ARMED : SEQ_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
            seq_q <= SEQ_IDLE;
        end else begin
            seq_q <= seq_d;
            if (restart) begin
                cnt_q <= '0;
                en_q  <= 1'b1;
            end else if (timeout) begin
                cnt_q <= '0;
                en_q  <= 1'b0;
            end else if (en_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fire_q <= 1'b0;
        else     fire_q <= timeout;
    end

    assign en_o = en_q;

endmodule

// File: rtl/rstctl_aux.sv
module rstctl_aux
    import rstctl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] AUX_ADDR = DEF_AUX_ADDR,
    parameter int unsigned       DIS_BIT  = DEF_DIS_BIT
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  reg_wr_t wr,
    output logic    dis_q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            dis_q <= 1'b0;
        else if (wr_hits(wr, AUX_ADDR))
            dis_q <= wr.data[DIS_BIT];
    end
endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
    parameter int unsigned LEN = 98
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic oe
);
    localparam int unsigned   CW   = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (start)
            left_q <= LOAD;
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign oe = (left_q != '0);
endmodule

// File: rtl/wdt_reset_ctrl.sv
module wdt_reset_ctrl
    import rstctl_pkg::*;
#(
    parameter int unsigned       WDT_W       = DEF_WDT_W,
    parameter int unsigned       STRETCH_LEN = DEF_STRETCH_LEN,
    parameter int unsigned       PAD_SAMPLES = DEF_PAD_SAMPLES,
    parameter logic [ADDR_W-1:0] KEY_ADDR    = DEF_KEY_ADDR,
    parameter logic [ADDR_W-1:0] AUX_ADDR    = DEF_AUX_ADDR,
    parameter int unsigned       DIS_BIT     = DEF_DIS_BIT,
    parameter logic [DATA_W-1:0] KEY_A       = DEF_KEY_A,
    parameter logic [DATA_W-1:0] KEY_B       = DEF_KEY_B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mc_stb,
    input  logic              pad_in,
    output logic              pad_oe,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sys_rst
);
    reg_wr_t wr;
    logic    ext_rst, timeout, fire_q, wdt_en, dis_q;

    assign wr = '{en: wr_en, addr: wr_addr, data: wr_data};

    rstctl_pad_filter #(.SAMPLES(PAD_SAMPLES)) u_pad (
        .clk(clk), .rst(rst), .mc_stb(mc_stb), .pad_in(pad_in), .ext_rst(ext_rst)
    );

    rstctl_wdt #(
        .CNT_W(WDT_W), .KEY_ADDR(KEY_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)
    ) u_wdt (
        .clk(clk), .rst(rst), .clr(sys_rst), .wr(wr),
        .timeout(timeout), .fire_q(fire_q), .en_o(wdt_en)
    );

    rstctl_aux #(.AUX_ADDR(AUX_ADDR), .DIS_BIT(DIS_BIT)) u_aux (
        .clk(clk), .rst(rst), .clr(sys_rst), .wr(wr), .dis_q(dis_q)
    );

    rstctl_stretch #(.LEN(STRETCH_LEN)) u_str (
        .clk(clk), .rst(rst), .start(timeout && !dis_q), .oe(pad_oe)
    );

    assign sys_rst = ext_rst || fire_q;

endmodule

// File: rtl/wdt_reset_ctrl_chk.sv
module wdt_reset_ctrl_chk #(
    parameter int unsigned STRETCH_LEN = 98
) (
    input logic clk,
    input logic rst,
    input logic mc_stb,
    input logic sys_rst,
    input logic pad_oe,
    input logic timeout,
    input logic fire_q,
    input logic dis_q,
    input logic wdt_en
);
    int unsigned oe_len;

    always_ff @(posedge clk) begin
        if (rst)         oe_len <= 0;
        else if (pad_oe) oe_len <= oe_len + 1;
        else             oe_len <= 0;
    end

    // R2: a pad-driven reset can only begin on a machine-cycle strobe
    a_r2_pad_on_strobe: assert property (@(posedge clk) disable iff (rst)
        ($rose(sys_rst) && !fire_q) |-> $past(mc_stb));

    // R7: pad drive starts together with the internal reset
    a_r7_oe_with_reset: assert property (@(posedge clk) disable iff (rst)
        $rose(pad_oe) |-> sys_rst);

    // R7: pad drive lasts the full stretch length
    a_r7_oe_length: assert property (@(posedge clk) disable iff (rst)
        $fell(pad_oe) |-> (oe_len == STRETCH_LEN));

    // R8: suppress bit keeps the pad undriven on a timeout
    a_r8_suppressed: assert property (@(posedge clk) disable iff (rst)
        (timeout && dis_q) |=> !pad_oe);

    // R9: watchdog reset pulse is a single cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fire_q |=> !fire_q);

    // R10: internal reset leaves the watchdog idle
    a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
        sys_rst |=> !wdt_en);

endmodule

bind wdt_reset_ctrl wdt_reset_ctrl_chk #(.STRETCH_LEN(STRETCH_LEN)) u_chk (
    .clk(clk), .rst(rst), .mc_stb(mc_stb), .sys_rst(sys_rst), .pad_oe(pad_oe),
    .timeout(timeout), .fire_q(fire_q), .dis_q(dis_q), .wdt_en(wdt_en)
);

// File: tb/sim_wdt_reset_ctrl.sv
`timescale 1ns/1ps
module sim_wdt_reset_ctrl;
    localparam int PERIOD = 16384;
    localparam int STRETCH = 98;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mc_stb = 1'b0;
    logic       pad_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       pad_oe, sys_rst;

    int ncyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int    q_cyc[$];
    bit    q_rst[$];
    bit    q_oe[$];
    string q_tag[$];

    wdt_reset_ctrl u0 (
        .clk(clk), .rst(rst), .mc_stb(mc_stb), .pad_in(pad_in), .pad_oe(pad_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sys_rst(sys_rst)
    );

    always #2 clk = ~clk;

    initial forever begin
        @(posedge clk);
        ncyc++;
    end

    // machine-cycle strobe: strobe edges fall on multiples of 12
    initial forever begin
        @(negedge clk);
        mc_stb = ((ncyc % 12) == 11);
    end

    // monitor: compare queued expectations when their edge count is reached
    initial forever begin
        @(negedge clk);
        while (q_cyc.size() > 0 && q_cyc[0] <= ncyc) begin
            n_cmp++;
            if (q_cyc[0] < ncyc) begin
                n_bad++;
                $display("FAIL %s: check for cycle %0d missed (actual cycle %0d, expected %0d)",
                         q_tag[0], q_cyc[0], ncyc, q_cyc[0]);
            end else if (sys_rst !== q_rst[0] || pad_oe !== q_oe[0]) begin
                n_bad++;
                $display("FAIL %s at cycle %0d: actual sys_rst=%b pad_oe=%b, expected sys_rst=%b pad_oe=%b",
                         q_tag[0], ncyc, sys_rst, pad_oe, q_rst[0], q_oe[0]);
            end
            void'(q_cyc.pop_front());
            void'(q_rst.pop_front());
            void'(q_oe.pop_front());
            void'(q_tag.pop_front());
        end
    end

    task automatic push(input int c, input bit r, input bit o, input string t);
        q_cyc.push_back(c);
        q_rst.push_back(r);
        q_oe.push_back(o);
        q_tag.push_back(t);
    endtask

    task automatic wait_to(input int c);
        while (ncyc < c) @(negedge clk);
    endtask

    task automatic align12();
        @(negedge clk);
        while ((ncyc % 12) != 0) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, output int applied);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        applied = ncyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic key_seq(output int e);
        int t;
        wr(8'hA6, 8'h1E, t);
        wr(8'hA6, 8'hE1, e);
    endtask

    // expected result of a timeout due at edge f
    task automatic expect_fire(input int f, input bit oe, input string t);
        push(f - 1, 1'b0, 1'b0, t);
        push(f, 1'b1, oe, t);
        push(f + 1, 1'b0, oe, t);
        if (oe) begin
            push(f + STRETCH - 1, 1'b0, 1'b1, "R7");
            push(f + STRETCH, 1'b0, 1'b0, "R7");
        end else begin
            push(f + STRETCH - 1, 1'b0, 1'b0, "R8");
        end
    endtask

    task automatic drain();
        if (q_cyc.size() > 0) wait_to(q_cyc[q_cyc.size()-1] + 1);
        @(negedge clk);
    endtask

    initial begin
        int n, m, e, e2, t;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        n = ncyc;
        // R1: reset state and idle watchdog
        push(n + 1, 1'b0, 1'b0, "R1");
        push(n + PERIOD + 20, 1'b0, 1'b0, "R1");
        drain();

        // R2/R3: pad held high across two strobes, then released
        align12();
        pad_in = 1'b1; n = ncyc;
        push(n + 23, 1'b0, 1'b0, "R2");
        push(n + 24, 1'b1, 1'b0, "R2");
        push(n + 35, 1'b1, 1'b0, "R3");
        push(n + 36, 1'b0, 1'b0, "R3");
        wait_to(n + 30);
        pad_in = 1'b0;
        drain();
        // R2: single high sample is not enough
        align12();
        pad_in = 1'b1; m = ncyc;
        push(m + 12, 1'b0, 1'b0, "R2");
        push(m + 24, 1'b0, 1'b0, "R2");
        wait_to(m + 13);
        pad_in = 1'b0;
        drain();

        // R4/R7/R9: timeout after key sequence, pad stretch, single pulse
        key_seq(e);
        expect_fire(e + PERIOD, 1'b1, "R4");
        push(e + 2*PERIOD + 200, 1'b0, 1'b0, "R9");
        drain();

        // R6: restart moves the timeout
        key_seq(e);
        wait_to(e + 10000);
        key_seq(e2);
        push(e + PERIOD, 1'b0, 1'b0, "R6");
        expect_fire(e2 + PERIOD, 1'b1, "R6");
        drain();

        // R5: incomplete or corrupted sequences do not start the watchdog
        wr(8'hA6, 8'hE1, t);
        wr(8'hA6, 8'h1E, t);
        wr(8'hA6, 8'h55, t);
        wr(8'hA6, 8'hE1, t);
        wr(8'hA6, 8'h1E, t);
        wr(8'h8E, 8'hE1, t);
        push(t + PERIOD, 1'b0, 1'b0, "R5");
        push(t + PERIOD + 200, 1'b0, 1'b0, "R5");
        drain();

        // R8: suppress bit (bit 3 at 0x8E) blocks pad drive only
        wr(8'h8E, 8'h08, t);
        key_seq(e);
        expect_fire(e + PERIOD, 1'b0, "R8");
        drain();

        // R10: the timeout reset cleared the suppress bit
        key_seq(e);
        expect_fire(e + PERIOD, 1'b1, "R10");
        drain();

        // R10: pad reset returns the watchdog to idle
        key_seq(e);
        align12();
        pad_in = 1'b1; n = ncyc;
        push(n + 24, 1'b1, 1'b0, "R10");
        wait_to(n + 30);
        pad_in = 1'b0;
        push(e + PERIOD, 1'b0, 1'b0, "R10");
        push(e + PERIOD + 100, 1'b0, 1'b0, "R10");
        drain();

        done = 1'b1;
    end

    initial begin
        while (!done && ncyc < 195000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL guard: run not finished (actual cycle %0d, expected done before 195000)", ncyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule